// File: doc/BRIEF.md
# Program/Erase Status Read Generator

This block chooses the byte returned on a read of a flash-style storage device. While an internal program or erase runs, it returns a status byte in place of array data. That status byte carries two independent ways to detect the end of the operation. The first is a polarity flag, which returns the inverse of the top bit of the byte being written. The second is a toggle flag, which changes value after every completed read strobe. When the device is idle, the array byte passes through. In identification mode, the block returns fixed identification codes and the boot-region lock state instead.

A host may start polling at any point in an operation, without first aligning to it. The host keeps reading until the polarity flag matches the data it wrote, or until two reads in a row show the same toggle flag. Read-path tri-state timing and the storage array itself belong to other blocks.

Top module: `pe_status_reader`

## Requirements
- R1: While `busy` is high and `op_erase` is low, the status byte has bit 7 equal to the inverse of `pgm_byte[7]` and bits 5..0 all zero.
- R2: The toggle flag sits in bit 6 of the status byte. It is 0 after reset. It inverts once for each completed read while `busy` is high. A read completes when `rd_act` was high in one cycle and is low in the next. At all other times the flag holds, including while `rd_act` stays high.
- R3: While `busy` is high and `op_erase` is high, status bit 7 is 0 and bits 5..0 are all zero.
- R4: When `busy` is low and `id_mode` is low, `rd_data` equals `array_data`.
- R5: When `busy` is low and `id_mode` is high with `addr` bits above bit 1 all zero, the low two address bits select the returned byte. A value of 0 returns 8'h1F, 1 returns 8'h13, and 3 returns 8'h0F.
- R6: In identification mode at address 2, `rd_data` is `{7'b0, lock_on}`.
- R7: In identification mode, any address with a nonzero bit above bit 1 returns 8'h00.
- R8: `busy` takes precedence over `id_mode`.
- R9: `rd_data` is registered: it reflects the inputs sampled at the previous rising clock edge, and it is 8'h00 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busy | input | 1 | Internal program or erase in progress |
| op_erase | input | 1 | Current operation is an erase (1) or a byte program (0) |
| pgm_byte | input | 8 | Last byte loaded for programming |
| rd_act | input | 1 | Read strobe, active high; a high-to-low step completes a read |
| id_mode | input | 1 | Identification mode active |
| lock_on | input | 1 | Boot-region lockout state |
| addr | input | 19 | Read address |
| array_data | input | 8 | Byte read from the storage array |
| rd_data | output | 8 | Byte returned to the reader |

## Verification
Each byte returned is due exactly one rising edge after its inputs are presented. The bench drives inputs on the falling edge and compares `rd_data` on the following falling edge, after a single register stage. The toggle flag is the one result that lags further. A read completing at one edge changes the flag at that edge, and the change shows in `rd_data` one edge later. The bench's cycle model therefore updates its flag only after it has formed the expected byte for that cycle. Long held strobes and busy transitions in the middle of a poll are driven on purpose, to show that the flag moves only on completed reads.

// File: rtl/pe_status_pkg.sv
package pe_status_pkg;
   typedef enum logic [1:0] {
      SRC_ARRAY  = 2'd0,
      SRC_STATUS = 2'd1,
      SRC_IDENT  = 2'd2
   } src_e;

   function automatic src_e pick_src(input logic busy, input logic id_mode);
      if (busy)         return SRC_STATUS;
      else if (id_mode) return SRC_IDENT;
      else              return SRC_ARRAY;
   endfunction
endpackage

// File: rtl/pe_toggle_trk.sv
module pe_toggle_trk (
   input  logic clk,
   input  logic rst_n,
   input  logic busy,
   input  logic rd_act,
   output logic tog_q
);
   logic rd_q;
   logic rd_done;

   assign rd_done = rd_q & ~rd_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q  <= 1'b0;
         tog_q <= 1'b0;
      end else begin
         rd_q <= rd_act;
         if (busy && rd_done) tog_q <= ~tog_q;
      end
   end
endmodule

// File: rtl/pe_ident_rom.sv
module pe_ident_rom #(
   parameter int          DATA_W    = 8,
   parameter int          ADDR_W    = 19,
   parameter logic [7:0]  MFR_CODE  = 8'h1F,
   parameter logic [7:0]  DEV_CODE  = 8'h13,
   parameter logic [7:0]  EXT_CODE  = 8'h0F
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              lock_on,
   output logic [DATA_W-1:0] id_byte
);
   localparam int SEL_W = 2;

   logic             upper_zero;
   logic [SEL_W-1:0] sel;

   assign upper_zero = (addr[ADDR_W-1:SEL_W] == '0);
   assign sel        = addr[SEL_W-1:0];

   always_comb begin
      id_byte = '0;
      if (upper_zero) begin
         case (sel)
            2'd0:    id_byte = DATA_W'(MFR_CODE);
            2'd1:    id_byte = DATA_W'(DEV_CODE);
            2'd2:    id_byte = DATA_W'(lock_on);
            default: id_byte = DATA_W'(EXT_CODE);
         endcase
      end
   end
endmodule

// File: rtl/pe_status_fmt.sv
module pe_status_fmt #(
   parameter int DATA_W     = 8,
   parameter int POLL_BIT   = 7,
   parameter int TOGGLE_BIT = 6
) (
   input  logic              op_erase,
   input  logic              pgm_top,
   input  logic              tog,
   output logic [DATA_W-1:0] status
);
   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      if (b == POLL_BIT) begin : g_poll
         assign status[b] = op_erase ? 1'b0 : ~pgm_top;
      end else if (b == TOGGLE_BIT) begin : g_tog
         assign status[b] = tog;
      end else begin : g_zero
         assign status[b] = 1'b0;
      end
   end
endmodule

// File: rtl/pe_status_reader.sv
module pe_status_reader #(
   parameter int          DATA_W     = 8,
   parameter int          ADDR_W     = 19,
   parameter int          POLL_BIT   = 7,
   parameter int          TOGGLE_BIT = 6,
   parameter logic [7:0]  MFR_CODE   = 8'h1F,
   parameter logic [7:0]  DEV_CODE   = 8'h13,
   parameter logic [7:0]  EXT_CODE   = 8'h0F,
   parameter bit          OUT_REG    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy,
   input  logic              op_erase,
   input  logic [DATA_W-1:0] pgm_byte,
   input  logic              rd_act,
   input  logic              id_mode,
   input  logic              lock_on,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] array_data,
   output logic [DATA_W-1:0] rd_data
);
   import pe_status_pkg::*;

   if (DATA_W < 8) begin : g_bad_width
      $error("DATA_W must be at least 8");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("ADDR_W must be at least 3");
   end
   if (POLL_BIT == TOGGLE_BIT || POLL_BIT >= DATA_W || TOGGLE_BIT >= DATA_W) begin : g_bad_bits
      $error("flag bit positions must be distinct and inside the data word");
   end

   logic              tog_now;
   logic [DATA_W-1:0] status_byte;
   logic [DATA_W-1:0] id_byte;
   logic [DATA_W-1:0] next_byte;
   logic              unused_pgm;
   src_e              src;

   assign unused_pgm = ^pgm_byte;

   pe_toggle_trk u_tog (
      .clk    (clk),
      .rst_n  (rst_n),
      .busy   (busy),
      .rd_act (rd_act),
      .tog_q  (tog_now)
   );

   pe_status_fmt #(
      .DATA_W     (DATA_W),
      .POLL_BIT   (POLL_BIT),
      .TOGGLE_BIT (TOGGLE_BIT)
   ) u_fmt (
      .op_erase (op_erase),
      .pgm_top  (pgm_byte[POLL_BIT]),
      .tog      (tog_now),
      .status   (status_byte)
   );

   pe_ident_rom #(
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W),
      .MFR_CODE (MFR_CODE),
      .DEV_CODE (DEV_CODE),
      .EXT_CODE (EXT_CODE)
   ) u_id (
      .addr    (addr),
      .lock_on (lock_on),
      .id_byte (id_byte)
   );

   assign src = pick_src(busy, id_mode);

   always_comb begin
      case (src)
         SRC_STATUS: next_byte = status_byte;
         SRC_IDENT:  next_byte = id_byte;
         default:    next_byte = array_data;
      endcase
   end

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rd_data <= '0;
         else        rd_data <= next_byte;
      end
   end else begin : g_comb
      assign rd_data = next_byte;
   end
endmodule

// File: rtl/pe_status_reader_chk.sv
module pe_status_reader_chk #(
   parameter int DATA_W  = 8,
   parameter int ADDR_W  = 19,
   parameter bit OUT_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              op_erase,
   input logic [DATA_W-1:0] pgm_byte,
   input logic              rd_act,
   input logic              id_mode,
   input logic              lock_on,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] array_data,
   input logic [DATA_W-1:0] rd_data,
   input logic              tog_now
);
   if (OUT_REG) begin : g_props
      // R1
      a_r1_poll_inverts: assert property (@(posedge clk) disable iff (!rst_n)
         busy && !op_erase |=> rd_data[7] == ~$past(pgm_byte[7]) && rd_data[5:0] == '0);
      // R3
      a_r3_erase_zero: assert property (@(posedge clk) disable iff (!rst_n)
         busy && op_erase |=> rd_data[7] == 1'b0 && rd_data[5:0] == '0);
      // R2
      a_r2_flag_shown: assert property (@(posedge clk) disable iff (!rst_n)
         busy |=> rd_data[6] == $past(tog_now));
      // R2
      a_r2_flip_on_done: assert property (@(posedge clk) disable iff (!rst_n)
         busy && $past(rd_act) && !rd_act |=> tog_now != $past(tog_now));
      // R2
      a_r2_hold_on_level: assert property (@(posedge clk) disable iff (!rst_n)
         rd_act |=> $stable(tog_now));
      // R4
      a_r4_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
         !busy && !id_mode |=> rd_data == $past(array_data));
      // R6
      a_r6_lock_read: assert property (@(posedge clk) disable iff (!rst_n)
         !busy && id_mode && addr == ADDR_W'(2) |=> rd_data == {{(DATA_W-1){1'b0}}, $past(lock_on)});
      // R5
      a_r5_mfr_code: assert property (@(posedge clk) disable iff (!rst_n)
         !busy && id_mode && addr == '0 |=> rd_data == DATA_W'(8'h1F));
      // R7
      a_r7_outside_zero: assert property (@(posedge clk) disable iff (!rst_n)
         !busy && id_mode && addr[ADDR_W-1:2] != '0 |=> rd_data == '0);
   end
endmodule

bind pe_status_reader pe_status_reader_chk #(
   .DATA_W  (DATA_W),
   .ADDR_W  (ADDR_W),
   .OUT_REG (OUT_REG)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy       (busy),
   .op_erase   (op_erase),
   .pgm_byte   (pgm_byte),
   .rd_act     (rd_act),
   .id_mode    (id_mode),
   .lock_on    (lock_on),
   .addr       (addr),
   .array_data (array_data),
   .rd_data    (rd_data),
   .tog_now    (tog_now)
);

// File: tb/pe_status_reader_tb.sv
module pe_status_reader_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        busy = 1'b0, op_erase = 1'b0, rd_act = 1'b0, id_mode = 1'b0, lock_on = 1'b0;
   logic [7:0]  pgm_byte = '0, array_data = '0;
   logic [18:0] addr = '0;
   logic [7:0]  rd_data;

   int n_chk = 0, n_bad = 0;
   logic m_tog = 1'b0, m_rdq = 1'b0;

   always #2.5 clk = ~clk;

   pe_status_reader u_dut (
      .clk(clk), .rst_n(rst_n), .busy(busy), .op_erase(op_erase),
      .pgm_byte(pgm_byte), .rd_act(rd_act), .id_mode(id_mode),
      .lock_on(lock_on), .addr(addr), .array_data(array_data), .rd_data(rd_data)
   );

   function automatic logic [7:0] exp_byte(logic tg);
      if (busy) begin
         if (op_erase) return {1'b0, tg, 6'b0};
         return {~pgm_byte[7], tg, 6'b0};
      end
      if (id_mode) begin
         if (addr[18:2] != '0) return 8'h00;
         case (addr[1:0])
            2'd0: return 8'h1F;
            2'd1: return 8'h13;
            2'd2: return {7'b0, lock_on};
            default: return 8'h0F;
         endcase
      end
      return array_data;
   endfunction

   function automatic string tag_of();
      if (busy && id_mode) return "R8";
      if (busy) return op_erase ? "R3/R2" : "R1/R2";
      if (id_mode) begin
         if (addr[18:2] != '0) return "R7";
         if (addr[1:0] == 2'd2) return "R6";
         return "R5";
      end
      return "R4";
   endfunction

   task automatic check(string tag, logic [7:0] exp);
      n_chk++;
      if (rd_data !== exp) begin
         n_bad++;
         $display("FAIL %s: rd_data=%h expected=%h", tag, rd_data, exp);
      end
   endtask

   // one clock step: inputs already driven; compare at next falling edge
   task automatic step();
      logic [7:0] e;
      string t;
      @(posedge clk);
      e = exp_byte(m_tog);
      t = tag_of();
      if (busy && m_rdq && !rd_act) m_tog = ~m_tog;
      m_rdq = rd_act;
      @(negedge clk);
      check(t, e);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      check("R9 reset", 8'h00);
      rst_n = 1'b1;
      @(negedge clk);

      // R4 idle pass-through
      array_data = 8'hA5; step();
      array_data = 8'h3C; step();

      // R5 / R6 / R7 identification reads
      id_mode = 1'b1;
      addr = 19'd0; step();
      addr = 19'd1; step();
      addr = 19'd3; step();
      lock_on = 1'b0; addr = 19'd2; step();
      lock_on = 1'b1; step();
      addr = 19'h40001; step();
      addr = 19'd4; step();

      // R1 / R2 program polling, R8 busy over id mode
      busy = 1'b1; op_erase = 1'b0; pgm_byte = 8'h80; addr = 19'd0;
      step();
      for (int i = 0; i < 4; i++) begin
         rd_act = 1'b1; step();
         rd_act = 1'b0; step();
      end
      id_mode = 1'b0;
      // R2: strobe held high many cycles must not flip flag
      rd_act = 1'b1;
      repeat (6) step();
      rd_act = 1'b0; step(); step();

      // R3 erase polling
      op_erase = 1'b1; pgm_byte = 8'h00;
      for (int i = 0; i < 3; i++) begin
         rd_act = 1'b1; step();
         rd_act = 1'b0; step();
      end
      // R2: read completing while idle must not flip flag
      busy = 1'b0; rd_act = 1'b1; step();
      rd_act = 1'b0; step();
      busy = 1'b1; step();

      // random mix
      for (int i = 0; i < 3000; i++) begin
         busy       = ($urandom % 3) != 0;
         op_erase   = $urandom % 2;
         pgm_byte   = 8'($urandom);
         rd_act     = $urandom % 2;
         id_mode    = $urandom % 2;
         lock_on    = $urandom % 2;
         addr       = ($urandom % 2) ? 19'($urandom % 4) : 19'($urandom);
         array_data = 8'($urandom);
         step();
      end

      // R9 reset clears output and flag
      rst_n = 1'b0; m_tog = 1'b0; m_rdq = 1'b0;
      @(negedge clk);
      check("R9 reset", 8'h00);
      rst_n = 1'b1; busy = 1'b1; op_erase = 1'b1; rd_act = 1'b0;
      step();

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule